// File: doc/BRIEF.md
# Network Interface Interrupt Controller

This block turns event pulses from a network interface's receive and transmit engines into a single interrupt line to the host. Each event pulse sets a bit in a status register. The line is raised when the global enable is on and at least one status bit is also set in the mask register. Some events raise the line at once. The others raise it only after a programmable holdoff, so that a burst of completions can share one interrupt.

Two of the events come from FIFO level crossings and have hysteresis. The receive-high-level event passes only after the receive FIFO has been seen empty since the last one passed. The transmit-low-level event passes only after the transmit FIFO has been seen full. The host reaches five registers through a plain single-cycle read/write port:

| Address | Register |
|---|---|
| 0 | config |
| 1 | command |
| 2 | status |
| 3 | mask |
| 4 | holdoff |

Reading status clears it. Writing status clears only the bits written as one. Any attempt to touch a reserved status bit is refused and reported on an error pin.

Top module: `nic_irq_ctrl`

## Requirements

- R1: A cycle with `ev_i` bit n high (n in 0..8, no reserved bit set) sets status bit n at the next clock edge. The event bits are:
  - 0: receive DMA done
  - 1: receive packet
  - 2: receive high level
  - 3: receive empty
  - 4: transmit DMA done
  - 5: transmit packet
  - 6: transmit low level
  - 7: transmit full
  - 8: software interrupt
- R2: A host read of address 2 returns status on `host_rdata_o` in the same cycle, and every status bit is zero after that edge. Events posted in that same cycle still land.
- R3: A host write to address 2 clears exactly the status bits whose write-data bit is one. Other bits keep their value.
- R4: Bits 9 to STAT_W-1 are reserved. Any of the following is rejected as a whole and leaves status unchanged:
  - an event vector with a reserved bit set;
  - a status write with a reserved bit set.

  `err_o` is high for the one cycle after a rejection.
- R5: Receive-high (bit 2) is recorded only when armed. The arm is set at reset and by receive-empty (bit 3). Recording bit 2 consumes the arm, so a second bit-2 pulse with no bit-3 pulse in between is dropped.
- R6: Transmit-low (bit 6) is recorded only when armed by transmit-full (bit 7). The arm is clear after reset, and recording bit 6 consumes it.
- R7: Immediate events (IMM_MASK, default bits 2, 6 and 8) raise `irq_o` at the same edge that sets their status bit. Any other event raises `irq_o` exactly D edges later, where D is the holdoff register, provided enable and mask allow it throughout.
- R8: `irq_o` is high only while config bit 0 is set and status AND mask is nonzero. When that condition fails, a running holdoff is abandoned, and a later delayed event starts a fresh holdoff of D cycles.
- R9: When config bit 0 goes from 0 to 1 while status AND mask is nonzero, `irq_o` rises at that edge. When it is written to 0, `irq_o` falls at that edge.
- R10: A write to the mask register (address 3) that leaves status AND mask nonzero with enable on raises `irq_o` at that edge, with no new event needed.
- R11: Command writes (address 1) work as follows:
  - Bit 0 posts the software interrupt event (status bit 8).
  - Bit 1 returns every register, both arms and the holdoff counter to their reset values: config 0, mask 0, holdoff DELAY_RST, status 0.
- R12: The holdoff register (address 4) reads back its written value and sets D. A value of 0 makes every event immediate.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | STAT_W | One-cycle event pulses, one bit per event |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe |
| host_addr_i | input | 3 | Host register address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Read data; valid in the cycle `host_rd_i` is high |
| irq_o | output | 1 | Interrupt line to the host |
| err_o | output | 1 | Reserved-bit access was rejected (one cycle) |

## Verification

The bench builds the block with:
- DELAY_RST = 4;
- STAT_W = 16 and DATA_W = 32;
- the default immediate set (bits 2, 6 and 8).

The short holdoff lets the bench count the exact edge at which a delayed interrupt appears. It also makes a cancelled holdoff distinguishable from a surviving one within a few cycles. The seven reserved status bits give room to probe rejection on both the event path and the write-one-to-clear path. Reprogramming the holdoff to 2 and then 0 covers the programmable delay and its degenerate immediate case.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

  // Event bit positions (the hysteresis pairs and the soft bit are decoded by position)
  localparam int unsigned EV_RX_DMA   = 0;
  localparam int unsigned EV_RX_PKT   = 1;
  localparam int unsigned EV_RX_HIGH  = 2;
  localparam int unsigned EV_RX_EMPTY = 3;
  localparam int unsigned EV_TX_DMA   = 4;
  localparam int unsigned EV_TX_PKT   = 5;
  localparam int unsigned EV_TX_LOW   = 6;
  localparam int unsigned EV_TX_FULL  = 7;
  localparam int unsigned EV_SOFT     = 8;
  localparam int unsigned EV_COUNT    = 9;

  localparam int unsigned CFG_IRQ_EN  = 0;
  localparam int unsigned CMD_SOFT    = 0;
  localparam int unsigned CMD_RESET   = 1;

  typedef enum logic [2:0] {
    RA_CONFIG  = 3'd0,
    RA_COMMAND = 3'd1,
    RA_STATUS  = 3'd2,
    RA_MASK    = 3'd3,
    RA_DELAY   = 3'd4
  } reg_addr_e;

endpackage

// File: rtl/nic_irq_wmark.sv
// Hysteresis gate for one watermark event: passes only once per arming.
module nic_irq_wmark #(
  parameter bit ARM_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic accept_i,
  input  logic hit_i,
  input  logic rearm_i,
  output logic pass_o
);

  logic armed_q;

  assign pass_o = hit_i & armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      armed_q <= ARM_RST;
    end else if (accept_i) begin
      armed_q <= rearm_i | (armed_q & ~hit_i);
    end
  end

  // R5 (and R6 on the transmit instance): delivery consumes the arm
  assert_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && pass_o && !rearm_i && !flush_i) |=> !armed_q);

  // R6: an accepted re-arm leaves the gate armed
  assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && rearm_i && !flush_i) |=> armed_q);

endmodule

// File: rtl/nic_irq_status.sv
// Status register: event set, read-to-clear, write-one-to-clear, reserved-bit guard.
module nic_irq_status import nic_irq_pkg::*; #(
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [STAT_W-1:0] set_i,
  input  logic              post_bad_i,
  input  logic              rd_clr_i,
  input  logic              wr_clr_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] stat_nxt_o,
  output logic              err_o
);

  localparam logic [STAT_W-1:0] EV_MASK  = STAT_W'((1 << EV_COUNT) - 1);
  localparam logic [STAT_W-1:0] RSV_MASK = ~EV_MASK;

  logic wr_bad;

  assign wr_bad = wr_clr_i & (|(wr_data_i & RSV_MASK));

  always_comb begin
    stat_nxt_o = stat_o;
    if (rd_clr_i)             stat_nxt_o = '0;
    if (wr_clr_i && !wr_bad)  stat_nxt_o = stat_nxt_o & ~wr_data_i;
    if (!post_bad_i)          stat_nxt_o = stat_nxt_o | set_i;
    if (flush_i)              stat_nxt_o = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_o <= '0;
      err_o  <= 1'b0;
    end else begin
      stat_o <= stat_nxt_o;
      err_o  <= post_bad_i | wr_bad;
    end
  end

  // R4: a rejected access with nothing else acting leaves status untouched
  assert_reject_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((post_bad_i || set_i == '0) && !rd_clr_i && !(wr_clr_i && !wr_bad) && !flush_i)
      |=> $stable(stat_o));

  // R2: a status read with no accepted event empties the register
  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && (post_bad_i || set_i == '0)) |=> (stat_o == '0));

endmodule

// File: rtl/nic_irq_line.sv
// Interrupt line driver with holdoff counter.
module nic_irq_line #(
  parameter int unsigned DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               cond_nxt_i,
  input  logic               post_imm_i,
  input  logic               post_del_i,
  input  logic               refire_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               irq_o
);

  logic [DELAY_W-1:0] tmr_q, tmr_n;
  logic               irq_n, fire;

  always_comb begin
    fire  = post_imm_i | refire_i | (tmr_q == DELAY_W'(1)) |
            (post_del_i && delay_i == '0);
    irq_n = 1'b0;
    tmr_n = '0;
    if (!flush_i && cond_nxt_i) begin
      irq_n = irq_o | fire;
      if (!irq_n) begin
        if (tmr_q != '0)     tmr_n = tmr_q - 1'b1;
        else if (post_del_i) tmr_n = delay_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q <= '0;
      irq_o <= 1'b0;
    end else begin
      tmr_q <= tmr_n;
      irq_o <= irq_n;
    end
  end

  // R7: the counter only runs while the line is still low
  assert_tmr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q != '0) |-> !irq_o);

  // R7: expiry with the condition still true raises the line
  assert_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q == DELAY_W'(1) && cond_nxt_i && !flush_i) |=> irq_o);

endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl import nic_irq_pkg::*; #(
  parameter int unsigned       STAT_W    = 16,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       DELAY_W   = 8,
  parameter int unsigned       DELAY_RST = 8,
  parameter logic [STAT_W-1:0] IMM_MASK  = 'h144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [2:0]        host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              irq_o,
  output logic              err_o
);

  localparam logic [STAT_W-1:0] EV_MASK  = STAT_W'((1 << EV_COUNT) - 1);
  localparam logic [STAT_W-1:0] RSV_MASK = ~EV_MASK;
  localparam int unsigned       NUM_WM   = 2;
  localparam int unsigned WM_HIT [NUM_WM] = '{EV_RX_HIGH,  EV_TX_LOW};
  localparam int unsigned WM_ARM [NUM_WM] = '{EV_RX_EMPTY, EV_TX_FULL};
  localparam bit          WM_RST [NUM_WM] = '{1'b1,        1'b0};

  // Register state
  logic               cfg_en_q, cfg_en_n;
  logic [STAT_W-1:0]  mask_q, mask_n;
  logic [DELAY_W-1:0] delay_q, delay_n;
  logic [STAT_W-1:0]  stat_q, stat_nxt;

  // Decode
  logic cfg_wr, cmd_wr, cmd_soft, cmd_rst, stat_rd, stat_wr, mask_wr, dly_wr;
  logic unused_wdata_hi;

  assign cfg_wr   = host_wr_i && (host_addr_i == RA_CONFIG);
  assign cmd_wr   = host_wr_i && (host_addr_i == RA_COMMAND);
  assign stat_wr  = host_wr_i && (host_addr_i == RA_STATUS);
  assign mask_wr  = host_wr_i && (host_addr_i == RA_MASK);
  assign dly_wr   = host_wr_i && (host_addr_i == RA_DELAY);
  assign stat_rd  = host_rd_i && (host_addr_i == RA_STATUS);
  assign cmd_soft = cmd_wr & host_wdata_i[CMD_SOFT];
  assign cmd_rst  = cmd_wr & host_wdata_i[CMD_RESET];
  assign unused_wdata_hi = ^host_wdata_i[DATA_W-1:STAT_W];

  // Event path
  logic [STAT_W-1:0] ev_all, ev_gated, ev_post;
  logic [NUM_WM-1:0] wm_pass;
  logic              post_bad;

  assign ev_all   = ev_i | (cmd_soft ? (STAT_W'(1) << EV_SOFT) : '0);
  assign post_bad = |(ev_all & RSV_MASK);

  for (genvar g = 0; g < NUM_WM; g++) begin : g_wm
    nic_irq_wmark #(.ARM_RST(WM_RST[g])) u_wm (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush_i  (cmd_rst),
      .accept_i (!post_bad),
      .hit_i    (ev_all[WM_HIT[g]]),
      .rearm_i  (ev_all[WM_ARM[g]]),
      .pass_o   (wm_pass[g])
    );
  end

  always_comb begin
    ev_gated = ev_all;
    for (int g = 0; g < NUM_WM; g++) ev_gated[WM_HIT[g]] = wm_pass[g];
  end

  assign ev_post = (post_bad || cmd_rst) ? '0 : ev_gated;

  nic_irq_status #(.STAT_W(STAT_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (cmd_rst),
    .set_i      (ev_gated),
    .post_bad_i (post_bad),
    .rd_clr_i   (stat_rd),
    .wr_clr_i   (stat_wr),
    .wr_data_i  (host_wdata_i[STAT_W-1:0]),
    .stat_o     (stat_q),
    .stat_nxt_o (stat_nxt),
    .err_o      (err_o)
  );

  // Control registers
  always_comb begin
    cfg_en_n = cfg_wr  ? host_wdata_i[CFG_IRQ_EN]  : cfg_en_q;
    mask_n   = mask_wr ? host_wdata_i[STAT_W-1:0]  : mask_q;
    delay_n  = dly_wr  ? host_wdata_i[DELAY_W-1:0] : delay_q;
    if (cmd_rst) begin
      cfg_en_n = 1'b0;
      mask_n   = '0;
      delay_n  = DELAY_W'(DELAY_RST);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en_q <= 1'b0;
      mask_q   <= '0;
      delay_q  <= DELAY_W'(DELAY_RST);
    end else begin
      cfg_en_q <= cfg_en_n;
      mask_q   <= mask_n;
      delay_q  <= delay_n;
    end
  end

  // Line
  logic cond_n, en_rise;

  assign cond_n  = cfg_en_n && (|(stat_nxt & mask_n));
  assign en_rise = cfg_en_n & ~cfg_en_q;

  nic_irq_line #(.DELAY_W(DELAY_W)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (cmd_rst),
    .cond_nxt_i (cond_n),
    .post_imm_i (|(ev_post & IMM_MASK)),
    .post_del_i (|(ev_post & ~IMM_MASK)),
    .refire_i   (en_rise | mask_wr),
    .delay_i    (delay_q),
    .irq_o      (irq_o)
  );

  // Host read data
  always_comb begin
    host_rdata_o = '0;
    if (host_rd_i) begin
      case (host_addr_i)
        RA_CONFIG: host_rdata_o[CFG_IRQ_EN]   = cfg_en_q;
        RA_STATUS: host_rdata_o[STAT_W-1:0]   = stat_q;
        RA_MASK:   host_rdata_o[STAT_W-1:0]   = mask_q;
        RA_DELAY:  host_rdata_o[DELAY_W-1:0]  = delay_q;
        default:   host_rdata_o = '0;
      endcase
    end
  end

  // R8: the line never stands without enable and an unmasked status bit
  assert_irq_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cfg_en_q && (|(stat_q & mask_q))));

  // R9: enabling with a pending unmasked bit raises the line at once
  assert_en_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && cond_n) |=> irq_o);

  // R10: a mask write that exposes a pending bit raises the line at once
  assert_unmask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && cond_n && !cmd_rst) |=> irq_o);

  // R4: reserved status bits never hold a one
  always_ff @(posedge clk) begin
    if (rst_n) begin
      assert_rsv_clear_R4: assert ((stat_q & RSV_MASK) == '0);
    end
  end

endmodule

// File: tb/sim_nic_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nic_irq_ctrl;

  localparam int unsigned STAT_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DRST   = 4;

  localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_STAT = 3'd2,
                         A_MASK = 3'd3, A_DLY = 3'd4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [STAT_W-1:0] ev = '0;
  logic              hwr = 1'b0, hrd = 1'b0;
  logic [2:0]        haddr = '0;
  logic [DATA_W-1:0] hwdata = '0;
  logic [DATA_W-1:0] hrdata;
  logic              irq, err;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  nic_irq_ctrl #(.STAT_W(STAT_W), .DATA_W(DATA_W), .DELAY_W(8), .DELAY_RST(DRST)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .host_wr_i(hwr), .host_rd_i(hrd),
    .host_addr_i(haddr), .host_wdata_i(hwdata), .host_rdata_o(hrdata),
    .irq_o(irq), .err_o(err)
  );

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    hwr = 1'b1; haddr = a; hwdata = d;
    tick();
    hwr = 1'b0; hwdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    hrd = 1'b1; haddr = a;
    #1 v = hrdata;
    tick();
    hrd = 1'b0;
  endtask

  task automatic post(input logic [STAT_W-1:0] e);
    ev = e;
    tick();
    ev = '0;
  endtask

  task automatic clean();
    wr(A_CMD, 32'h2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R11 reset irq", {31'b0, irq}, 32'h0);
    chk("R4 reset err", {31'b0, err}, 32'h0);
    rd(A_STAT, v); chk("R11 reset status", v, 32'h0);
    rd(A_CFG, v);  chk("R11 reset config", v, 32'h0);
    rd(A_MASK, v); chk("R11 reset mask", v, 32'h0);
    rd(A_DLY, v);  chk("R12 reset holdoff", v, DRST);
  endtask

  task automatic t_post_read();
    logic [31:0] v;
    clean();
    post(16'h0002);
    rd(A_STAT, v); chk("R1 single event", v, 32'h002);
    rd(A_STAT, v); chk("R2 read clears", v, 32'h0);
    post(16'h0031);
    rd(A_STAT, v); chk("R1 multi event", v, 32'h031);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    clean();
    post(16'h0033);
    wr(A_STAT, 32'h011);
    rd(A_STAT, v); chk("R3 w1c", v, 32'h022);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    clean();
    post(16'h0201);
    chk("R4 post err", {31'b0, err}, 32'h1);
    rd(A_STAT, v); chk("R4 post rejected", v, 32'h0);
    chk("R4 err drops", {31'b0, err}, 32'h0);
    post(16'h0002);
    wr(A_STAT, 32'h8002);
    chk("R4 write err", {31'b0, err}, 32'h1);
    rd(A_STAT, v); chk("R4 write rejected", v, 32'h002);
  endtask

  task automatic t_rx_wmark();
    logic [31:0] v;
    clean();
    post(16'h0004);
    rd(A_STAT, v); chk("R5 armed at reset", v, 32'h004);
    post(16'h0004);
    rd(A_STAT, v); chk("R5 suppressed", v, 32'h0);
    post(16'h0008);
    rd(A_STAT, v); chk("R5 empty seen", v, 32'h008);
    post(16'h0004);
    rd(A_STAT, v); chk("R5 rearmed", v, 32'h004);
  endtask

  task automatic t_tx_wmark();
    logic [31:0] v;
    clean();
    post(16'h0040);
    rd(A_STAT, v); chk("R6 disarmed at reset", v, 32'h0);
    post(16'h0080);
    rd(A_STAT, v); chk("R6 full seen", v, 32'h080);
    post(16'h0040);
    rd(A_STAT, v); chk("R6 delivered", v, 32'h040);
    post(16'h0040);
    rd(A_STAT, v); chk("R6 consumed", v, 32'h0);
  endtask

  task automatic t_delay();
    logic [31:0] v;
    clean();
    wr(A_MASK, 32'h1FF);
    wr(A_CFG, 32'h1);
    post(16'h0001);
    chk("R7 delayed low at post", {31'b0, irq}, 32'h0);
    repeat (3) tick();
    chk("R7 delayed low before D", {31'b0, irq}, 32'h0);
    tick();
    chk("R7 delayed high at D", {31'b0, irq}, 32'h1);
    rd(A_STAT, v);
    chk("R8 drops on clear", {31'b0, irq}, 32'h0);
    post(16'h0004);
    chk("R7 immediate event", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_cancel();
    clean();
    wr(A_MASK, 32'h1FF);
    wr(A_CFG, 32'h1);
    post(16'h0001);
    wr(A_STAT, 32'h001);
    chk("R8 low after clear", {31'b0, irq}, 32'h0);
    post(16'h0002);
    repeat (2) tick();
    chk("R8 old holdoff abandoned", {31'b0, irq}, 32'h0);
    repeat (2) tick();
    chk("R8 fresh holdoff", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_enable();
    clean();
    wr(A_MASK, 32'h002);
    post(16'h0002);
    tick();
    chk("R9 disabled low", {31'b0, irq}, 32'h0);
    wr(A_CFG, 32'h1);
    chk("R9 enable rise", {31'b0, irq}, 32'h1);
    wr(A_CFG, 32'h0);
    chk("R9 enable fall", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_unmask();
    clean();
    wr(A_CFG, 32'h1);
    post(16'h0002);
    repeat (5) tick();
    chk("R10 masked low", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h002);
    chk("R10 unmask rise", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_command();
    logic [31:0] v;
    clean();
    wr(A_CFG, 32'h1);
    wr(A_MASK, 32'h100);
    wr(A_CMD, 32'h1);
    chk("R11 soft immediate", {31'b0, irq}, 32'h1);
    rd(A_STAT, v); chk("R11 soft status", v, 32'h100);
    wr(A_MASK, 32'h0FF);
    wr(A_DLY, 32'h9);
    post(16'h0080);
    wr(A_CMD, 32'h2);
    chk("R11 reset irq low", {31'b0, irq}, 32'h0);
    rd(A_CFG, v);  chk("R11 cmd reset config", v, 32'h0);
    rd(A_MASK, v); chk("R11 cmd reset mask", v, 32'h0);
    rd(A_DLY, v);  chk("R11 cmd reset holdoff", v, DRST);
    rd(A_STAT, v); chk("R11 cmd reset status", v, 32'h0);
    post(16'h0040);
    rd(A_STAT, v); chk("R11 cmd reset disarms tx", v, 32'h0);
  endtask

  task automatic t_delay_prog();
    logic [31:0] v;
    clean();
    wr(A_MASK, 32'h1FF);
    wr(A_CFG, 32'h1);
    wr(A_DLY, 32'h2);
    rd(A_DLY, v); chk("R12 holdoff readback", v, 32'h2);
    post(16'h0001);
    chk("R12 low at post", {31'b0, irq}, 32'h0);
    tick();
    chk("R12 low at 1", {31'b0, irq}, 32'h0);
    tick();
    chk("R12 high at 2", {31'b0, irq}, 32'h1);
    wr(A_DLY, 32'h0);
    rd(A_STAT, v);
    chk("R12 cleared", {31'b0, irq}, 32'h0);
    post(16'h0001);
    chk("R12 zero holdoff immediate", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_post_read();
    t_w1c();
    t_reserved();
    t_rx_wmark();
    t_tx_wmark();
    t_delay();
    t_cancel();
    t_enable();
    t_unmask();
    t_command();
    t_delay_prog();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

endmodule